// File: doc/BRIEF.md
# CAMAC Delay-Word Register Interface

This block is a slave on a CAMAC dataway. It keeps one 8-bit delay code for each of sixteen timing channels, and each code sets the delay of that channel's delay element. The programmed delay of a channel is a fixed minimum plus N steps, where N is the stored code and each step is 1/256 of the selected range. A code of zero therefore gives the minimum delay.

The crate controller addresses the module through its station line, a 4-bit subaddress that picks the channel, and a 5-bit function code. Function 16 stores the low eight write lines into the chosen channel on the S1 strobe. Function 0 places the chosen channel's code on the read lines. The module answers both of these functions with Q and X, and does not respond to any other function code. An initialize (Z) or clear (C) cycle, strobed by S2, sets every code to zero. All sixteen codes are always available on one flat parallel output that feeds the delay elements.

A state machine tracks each dataway cycle. Its states are:
- `ST_IDLE`: no cycle in progress.
- `ST_READ`: a read cycle.
- `ST_WRITE`: a write cycle waiting for its strobe.
- `ST_WRITTEN`: the write has been taken.
- `ST_REJECT`: an unsupported function code.
- `ST_INIT`: Z or C is seen and the machine waits for S2.
- `ST_CLEARED`: the bank has been zeroed.

Its transitions are:
- IDLE→INIT when Z or C is high.
- IDLE→READ, WRITE or REJECT when the station line is high, chosen by the decoded function.
- WRITE→WRITTEN on a rising edge of S1.
- INIT→CLEARED on a rising edge of S2.
- INIT→IDLE when Z and C fall without S2.
- CLEARED→IDLE when Z and C are both low.
- READ, WRITE, WRITTEN or REJECT→IDLE when the station line drops.
- Any of READ, WRITE, WRITTEN or REJECT→INIT when Z or C rises.

Top module: `camac_delay_regs`

## Requirements
- R1: After reset, all sixteen codes are zero, the read bus is zero, and Q and X are low.
- R2: While the station line is low, Q and X stay low, and S1 strobes change no code.
- R3: Take function 16 with subaddress a, and a rising edge of S1 sampled on a clock edge. At that same clock edge, `wr_bus[7:0]` is stored as the code of channel a. Channel a's code appears on `delay_words[8*a+7:8*a]`.
- R4: A write to channel a leaves the codes of all other channels unchanged. No code changes except through an accepted S1 write or an S2 clear.
- R5: Write lines `wr_bus[23:8]` do not affect the stored code.
- R6: In a function 0 cycle, `rd_bus[7:0]` shows the code of the addressed channel from the clock edge after the station line is sampled high until the station line drops. `rd_bus[23:8]` is always zero. A read that directly follows a write returns the value just written.
- R7: One clock edge after the station line is sampled high, Q and X both go high for function 0 or 16. For any other function code, both stay low, and an S1 strobe in that cycle stores nothing.
- R8: When Z or C is high and a rising edge of S2 follows, all sixteen codes become zero. If Z or C drops before any S2 edge, the codes are kept.
- R9: Only the first S1 edge in a write cycle is stored. Later S1 edges, up to the point where the station line drops, are ignored.
- R10: The read bus is zero outside a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all dataway inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stn_sel | input | 1 | Station select (N) for this module |
| sub_addr | input | 4 | Subaddress (A); selects the channel |
| func | input | 5 | Function code (F) |
| wr_bus | input | 24 | Dataway write lines; only bits 7:0 are used |
| s1 | input | 1 | First timing strobe; stores write data |
| s2 | input | 1 | Second timing strobe; performs initialize or clear |
| init_z | input | 1 | Dataway initialize (Z) |
| clear_c | input | 1 | Dataway clear (C) |
| rd_bus | output | 24 | Dataway read lines |
| q_resp | output | 1 | Q response |
| x_resp | output | 1 | X (command accepted) response |
| delay_words | output | 128 | All sixteen codes; channel i at bits 8*i+7:8*i |

## Verification
The command decode is registered, so Q, X and the read bus are due one clock edge after the station line is first sampled high. A code is written at the same edge where the S1 rising edge is sampled, and a clear at the edge where the S2 rising edge is sampled. The bench changes inputs on falling clock edges and samples each result at the next falling edge, which comes after exactly the one rising edge that produces it. The checks for ignored inputs look at all sixteen parallel codes one edge after the ignored strobe. Read-bus checks are repeated later in the same cycle to confirm that the value holds.

// File: rtl/camac_dly_pkg.sv
package camac_dly_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WRITTEN,
        ST_REJECT,
        ST_INIT,
        ST_CLEARED
    } dly_state_t;

    typedef enum logic [1:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_OTHER
    } cmd_kind_t;

    localparam int          FN_W     = 5;
    localparam logic [4:0]  FN_READ  = 5'd0;
    localparam logic [4:0]  FN_WRITE = 5'd16;

endpackage

// File: rtl/dly_strobe_edge.sv
module dly_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/dly_cmd_decode.sv
module dly_cmd_decode
    import camac_dly_pkg::*;
(
    input  logic [FN_W-1:0] func,
    output cmd_kind_t       kind
);
    always_comb begin
        case (func)
            FN_READ:  kind = CMD_READ;
            FN_WRITE: kind = CMD_WRITE;
            default:  kind = CMD_OTHER;
        endcase
    end
endmodule

// File: rtl/dly_word_bank.sv
module dly_word_bank #(
    parameter int NCH = 16,
    parameter int WW  = 8,
    parameter int AW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WW-1:0]     wdata,
    input  logic              clr,
    input  logic [AW-1:0]     raddr,
    output logic [WW-1:0]     rdata,
    output logic [NCH*WW-1:0] words_flat
);
    logic [WW-1:0] regs [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             regs[g] <= '0;
            else if (clr)                           regs[g] <= '0;
            else if (we && (waddr == AW'(g)))       regs[g] <= wdata;
        end
        assign words_flat[g*WW +: WW] = regs[g];
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/camac_delay_regs.sv
module camac_delay_regs
    import camac_dly_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int WW    = 8,
    parameter int BUS_W = 24,
    parameter int AW    = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stn_sel,
    input  logic [AW-1:0]     sub_addr,
    input  logic [4:0]        func,
    input  logic [BUS_W-1:0]  wr_bus,
    input  logic              s1,
    input  logic              s2,
    input  logic              init_z,
    input  logic              clear_c,
    output logic [BUS_W-1:0]  rd_bus,
    output logic              q_resp,
    output logic              x_resp,
    output logic [NCH*WW-1:0] delay_words
);
    localparam int PAD_W = BUS_W - WW;

    dly_state_t    st, st_nxt;
    cmd_kind_t     kind;
    logic [AW-1:0] cmd_addr;
    logic          s1_rise, s2_rise;
    logic          init_req;
    logic          bank_we, bank_clr;
    logic [WW-1:0] bank_rdata;
    logic          unused_hi;

    assign init_req  = init_z | clear_c;
    assign unused_hi = ^wr_bus[BUS_W-1:WW];

    dly_strobe_edge u_s1_edge (.clk(clk), .rst_n(rst_n), .level(s1), .rise(s1_rise));
    dly_strobe_edge u_s2_edge (.clk(clk), .rst_n(rst_n), .level(s2), .rise(s2_rise));

    dly_cmd_decode u_dec (.func(func), .kind(kind));

    dly_word_bank #(.NCH(NCH), .WW(WW), .AW(AW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bank_we),
        .waddr      (cmd_addr),
        .wdata      (wr_bus[WW-1:0]),
        .clr        (bank_clr),
        .raddr      (cmd_addr),
        .rdata      (bank_rdata),
        .words_flat (delay_words)
    );

    // state register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cmd_addr <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && stn_sel && !init_req)
                cmd_addr <= sub_addr;
        end
    end

    // next state and bank strobes
    always_comb begin
        st_nxt   = st;
        bank_we  = 1'b0;
        bank_clr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (init_req) st_nxt = ST_INIT;
                else if (stn_sel) begin
                    unique case (kind)
                        CMD_READ:  st_nxt = ST_READ;
                        CMD_WRITE: st_nxt = ST_WRITE;
                        default:   st_nxt = ST_REJECT;
                    endcase
                end
            end
            ST_WRITE: begin
                if (init_req)      st_nxt = ST_INIT;
                else if (!stn_sel) st_nxt = ST_IDLE;
                else if (s1_rise) begin
                    bank_we = 1'b1;
                    st_nxt  = ST_WRITTEN;
                end
            end
            ST_READ, ST_WRITTEN, ST_REJECT: begin
                if (init_req)      st_nxt = ST_INIT;
                else if (!stn_sel) st_nxt = ST_IDLE;
            end
            ST_INIT: begin
                if (s2_rise) begin
                    bank_clr = 1'b1;
                    st_nxt   = ST_CLEARED;
                end else if (!init_req) st_nxt = ST_IDLE;
            end
            ST_CLEARED: begin
                if (!init_req) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // dataway outputs
    always_comb begin
        q_resp = 1'b0;
        x_resp = 1'b0;
        rd_bus = '0;
        unique case (st)
            ST_READ: begin
                q_resp = 1'b1;
                x_resp = 1'b1;
                rd_bus = {{PAD_W{1'b0}}, bank_rdata};
            end
            ST_WRITE, ST_WRITTEN: begin
                q_resp = 1'b1;
                x_resp = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/camac_dly_checker.sv
module camac_dly_checker
    import camac_dly_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int WW    = 8,
    parameter int BUS_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stn_sel,
    input logic [4:0]        func,
    input logic              s1,
    input logic              s2,
    input logic              init_z,
    input logic              clear_c,
    input logic [BUS_W-1:0]  rd_bus,
    input logic              q_resp,
    input logic              x_resp,
    input logic [NCH*WW-1:0] delay_words,
    input dly_state_t        st
);
    logic s1_prev, s2_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_prev <= 1'b0;
            s2_prev <= 1'b0;
        end else begin
            s1_prev <= s1;
            s2_prev <= s2;
        end
    end

    // R2: no station select, no response on the next cycle
    assert_silent_no_station_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stn_sel |=> (!q_resp && !x_resp));

    // R4: codes move only on a strobe edge
    assert_words_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(s1 && !s1_prev) && !(s2 && !s2_prev)) |=> $stable(delay_words));

    // R6: upper read lines always zero
    assert_read_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bus[BUS_W-1:WW] == '0);

    // R7: Q and X go together
    assert_q_with_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_resp == x_resp);

    // R7: unsupported function is not answered
    assert_reject_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && stn_sel && !init_z && !clear_c && func != FN_READ && func != FN_WRITE)
        |=> !x_resp);

    // R8: S2 during initialize clears the bank
    assert_clear_on_s2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_INIT && s2 && !s2_prev) |=> (delay_words == '0));

    // R9: no second store in one write cycle
    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITTEN) |=> $stable(delay_words));

    // R10: read bus idle outside a read
    assert_read_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bus != '0) |-> q_resp);
endmodule

bind camac_delay_regs camac_dly_checker #(.NCH(NCH), .WW(WW), .BUS_W(BUS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stn_sel     (stn_sel),
    .func        (func),
    .s1          (s1),
    .s2          (s2),
    .init_z      (init_z),
    .clear_c     (clear_c),
    .rd_bus      (rd_bus),
    .q_resp      (q_resp),
    .x_resp      (x_resp),
    .delay_words (delay_words),
    .st          (st)
);

// File: tb/camac_delay_regs_tb_top.sv
module camac_delay_regs_tb_top;
    localparam int NCH = 16;
    localparam int WW  = 8;
    localparam int BW  = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stn_sel = 1'b0;
    logic [3:0]      sub_addr = '0;
    logic [4:0]      func = '0;
    logic [BW-1:0]   wr_bus = '0;
    logic            s1 = 1'b0, s2 = 1'b0, init_z = 1'b0, clear_c = 1'b0;
    logic [BW-1:0]   rd_bus;
    logic            q_resp, x_resp;
    logic [NCH*WW-1:0] delay_words;

    logic [WW-1:0] exp_w [NCH];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    camac_delay_regs dut_i (
        .clk(clk), .rst_n(rst_n), .stn_sel(stn_sel), .sub_addr(sub_addr), .func(func),
        .wr_bus(wr_bus), .s1(s1), .s2(s2), .init_z(init_z), .clear_c(clear_c),
        .rd_bus(rd_bus), .q_resp(q_resp), .x_resp(x_resp), .delay_words(delay_words)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_words(input string req);
        for (int i = 0; i < NCH; i++)
            check(req, 32'(delay_words[i*WW +: WW]), 32'(exp_w[i]));
    endtask

    task automatic begin_cycle(input logic [3:0] a, input logic [4:0] f);
        @(negedge clk);
        stn_sel = 1'b1; sub_addr = a; func = f;
        @(negedge clk);
    endtask

    task automatic pulse_s1(input logic [BW-1:0] d);
        wr_bus = d; s1 = 1'b1;
        @(negedge clk);
        s1 = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_cycle;
        stn_sel = 1'b0; func = '0; wr_bus = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [BW-1:0] d);
        begin_cycle(a, 5'd16);
        pulse_s1(d);
        exp_w[a] = d[WW-1:0];
        end_cycle();
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) exp_w[i] = '0;
        check_words("R1");
        check("R1", 32'(rd_bus), 0);
        check("R1", {30'd0, q_resp, x_resp}, 0);
    endtask

    task automatic t_write_read;
        begin_cycle(4'd5, 5'd16);
        check("R7", {30'd0, q_resp, x_resp}, 3);
        check("R10", 32'(rd_bus), 0);
        pulse_s1(24'hFF_C3A7);
        exp_w[5] = 8'hA7;
        check_words("R3");
        end_cycle();
        check_words("R4");
        begin_cycle(4'd5, 5'd0);
        check("R7", {30'd0, q_resp, x_resp}, 3);
        check("R6", 32'(rd_bus), 32'h0000A7);
        @(negedge clk); @(negedge clk);
        check("R6", 32'(rd_bus), 32'h0000A7);
        end_cycle();
        check("R10", 32'(rd_bus), 0);
        check("R5", 32'(delay_words[5*WW +: WW]), 32'hA7);
    endtask

    task automatic t_all_channels;
        for (int i = 0; i < NCH; i++) do_write(4'(i), 24'(i * 17 + 3) | 24'hAB0000);
        check_words("R4");
        for (int i = 0; i < NCH; i++) begin
            begin_cycle(4'(i), 5'd0);
            check("R6", 32'(rd_bus), 32'(exp_w[i]));
            end_cycle();
        end
        do_write(4'd0, 24'h0000FF);
        do_write(4'd15, 24'h000000);
        check_words("R3");
    endtask

    task automatic t_reject;
        begin_cycle(4'd2, 5'd8);
        check("R7", {30'd0, q_resp, x_resp}, 0);
        pulse_s1(24'h000055);
        check_words("R7");
        end_cycle();
        begin_cycle(4'd2, 5'd1);
        check("R7", {30'd0, q_resp, x_resp}, 0);
        check("R10", 32'(rd_bus), 0);
        end_cycle();
    endtask

    task automatic t_no_station;
        @(negedge clk);
        sub_addr = 4'd2; func = 5'd16;
        @(negedge clk);
        check("R2", {30'd0, q_resp, x_resp}, 0);
        pulse_s1(24'h000066);
        check_words("R2");
        func = '0;
    endtask

    task automatic t_double_strobe;
        begin_cycle(4'd3, 5'd16);
        pulse_s1(24'h000011);
        exp_w[3] = 8'h11;
        pulse_s1(24'h000022);
        check_words("R9");
        end_cycle();
        begin_cycle(4'd3, 5'd0);
        check("R9", 32'(rd_bus), 32'h11);
        end_cycle();
    endtask

    task automatic t_init;
        @(negedge clk); init_z = 1'b1;
        @(negedge clk); @(negedge clk);
        init_z = 1'b0;
        @(negedge clk); @(negedge clk);
        check_words("R8");
        clear_c = 1'b1;
        @(negedge clk);
        s2 = 1'b1;
        @(negedge clk);
        s2 = 1'b0;
        for (int i = 0; i < NCH; i++) exp_w[i] = '0;
        check_words("R8");
        clear_c = 1'b0;
        @(negedge clk); @(negedge clk);
        do_write(4'd9, 24'h00005A);
        init_z = 1'b1;
        @(negedge clk);
        s2 = 1'b1;
        @(negedge clk);
        s2 = 1'b0; init_z = 1'b0;
        exp_w[9] = '0;
        @(negedge clk);
        check_words("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_all_channels();
        t_reject();
        t_no_station();
        t_double_strobe();
        t_init();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule